// File: doc/BRIEF.md
# Inbound Backplane Window Decoder

This block sits between an external backplane bus and a local bus. It holds two independent inbound windows. For each incoming bus cycle it looks at the 32-bit bus address, the address width of the cycle (24-bit or 32-bit), the transfer kind and the privilege level. It then decides whether a window claims the cycle. When one does, it produces the local address, the write-post enable and the two snoop control bits of that window.

Each window is bounded by a start and an end value on address bits 31..16, so a window is 64KB to 4GB in size. Each window also has an eight-bit class enable byte that must accept the cycle. Upper address bits are translated in one of two ways. In replacement mode a per-bit select mask picks each bit from the translation value or from the bus. In offset mode a 16-bit offset is added to the upper bus bits. Address bits 15..0 pass through unchanged.

A small word-indexed register port with byte enables programs the windows. The decode path is purely combinational from the cycle inputs and the current register contents.

Top module: `inbound_window_map`

## Requirements
- R1: After reset, every register word reads as zero, and no cycle produces a hit.
- R2: The register words are indexed by `reg_word`:
  - Word 0 and word 1 hold the end value of window 1 and window 2 in bits 31..16 and the start value in bits 15..0.
  - Word 2 and word 3 hold the translation or offset value of window 1 and window 2 in bits 31..16 and the select mask in bits 15..0.
  - Word 4 holds the class enables of window 1 in bits 7..0 and its control byte in bits 15..8. Window 2 uses bits 23..16 and 31..24 in the same way.
  - A write changes only the bytes whose `reg_be` bit is set.
  - Control-byte bits 7..4 always read zero.
  - Words 5..7 read zero and ignore writes.
- R3: A window matches only if start ≤ S ≤ end, with both bounds inclusive. S is the 16-bit segment number taken from address bits 31..16.
- R4: When `bus_a24` is 1, the segment number S used for the compare and for translation has its upper eight bits forced to zero. S is then {8'h00, addr[23:16]}.
- R5: A window matches only if all three of its class groups accept the cycle:
  - The kind group uses enable bit `bus_kind`. The encoding is 0 = data, 1 = program, 2 = block, 3 = 64-bit block.
  - The width group uses bit 4 for A24 cycles and bit 5 for A32 cycles.
  - The privilege group uses bit 6 for user cycles and bit 7 for supervisor cycles (`bus_sup` = 1).
- R6: A window whose enable byte is zero never matches.
- R7: With control bit 3 clear (replacement mode), local bit 16+i comes from translation-value bit i where select bit i is 1, and from S bit i where it is 0.
- R8: With control bit 3 set (offset mode), local bits 31..16 equal (S + offset) modulo 2^16.
- R9: On a hit, `loc_addr[15:0]` equals `bus_addr[15:0]`.
- R10: If both windows match, window 1 wins and `hit_win` is 0. If only window 2 matches, `hit_win` is 1.
- R11: On a hit, `wpost` equals control bit 0 of the winning window and `snoop` equals its control bits 2..1. A snoop bit of 0 enables snooping and 1 inhibits it. With no hit, `loc_addr`, `wpost` and `snoop` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_word | input | 3 | Register word index |
| reg_be | input | 4 | Byte enables for writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the indexed word (combinational) |
| bus_addr | input | 32 | Incoming backplane address |
| bus_a24 | input | 1 | 1 = 24-bit address cycle, 0 = 32-bit |
| bus_kind | input | 2 | Transfer kind: 0 data, 1 program, 2 block, 3 64-bit block |
| bus_sup | input | 1 | 1 = supervisor, 0 = user |
| hit | output | 1 | A window claims the cycle |
| hit_win | output | 1 | Index of the winning window |
| loc_addr | output | 32 | Translated local address |
| wpost | output | 1 | Write-post enable of the winner |
| snoop | output | 2 | Snoop control bits of the winner |

## Verification
The bench sweeps segment numbers across both bounds of a window:
- A design with an exclusive bound loses the first or the last segment.
- A design that drops the A24 zeroing misses cycles whose high byte is set.

Every combination of enable byte, kind, width and privilege is checked, which catches a group that is wrongly ORed instead of ANDed, or a swapped bit position. Translation is checked with mixed select masks and with offsets that wrap past 16 bits. Overlapping windows with different control bytes are also checked, which catches a wrong priority or control taken from the losing window.

// File: rtl/inwin_pkg.sv
package inwin_pkg;

  localparam int ADDR_W    = 32;
  localparam int DATA_W    = 32;
  localparam int SEG_W     = 16;
  localparam int NUM_WIN   = 2;
  localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam int NUM_WORDS = 2 * NUM_WIN + 1;
  localparam int WORD_IDX_W = 3;
  localparam int CTL_WORD  = 2 * NUM_WIN;
  localparam int BYTES     = DATA_W / 8;
  localparam int EN_W      = 8;

  typedef struct packed {
    logic [SEG_W-1:0] seg_end;
    logic [SEG_W-1:0] seg_start;
    logic [SEG_W-1:0] xval;
    logic [SEG_W-1:0] xsel;
    logic [EN_W-1:0]  amsel;
    logic             adder;
    logic [1:0]       snoop;
    logic             wpost;
  } win_cfg_t;

  // writable bits per word; control bytes keep only their low nibble
  function automatic logic [DATA_W-1:0] word_mask(input int idx);
    return (idx == CTL_WORD) ? 32'h0FFF_0FFF : '1;
  endfunction

  // segment number used for compare and translation
  function automatic logic [SEG_W-1:0] seg_of(input logic [SEG_W-1:0] hi,
                                              input logic a24);
    return a24 ? {8'h00, hi[7:0]} : hi;
  endfunction

  // all three class groups must accept the cycle
  function automatic logic class_ok(input logic [EN_W-1:0] en,
                                    input logic [1:0] kind,
                                    input logic a24,
                                    input logic sup);
    logic k_ok, w_ok, p_ok;
    k_ok = en[kind];
    w_ok = a24 ? en[4] : en[5];
    p_ok = sup ? en[7] : en[6];
    return k_ok & w_ok & p_ok;
  endfunction

  function automatic logic [SEG_W-1:0] xlate(input logic [SEG_W-1:0] seg,
                                             input logic [SEG_W-1:0] xval,
                                             input logic [SEG_W-1:0] xsel,
                                             input logic adder);
    if (adder) return seg + xval;
    return (xval & xsel) | (seg & ~xsel);
  endfunction

endpackage

// File: rtl/inwin_regs.sv
module inwin_regs
  import inwin_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [WORD_IDX_W-1:0] reg_word,
  input  logic [BYTES-1:0]      reg_be,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output win_cfg_t              cfg [NUM_WIN]
);

  logic [DATA_W-1:0] word_q [NUM_WORDS];
  logic              word_ok;

  assign word_ok = (int'(reg_word) < NUM_WORDS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) word_q[i] <= '0;
    end else if (reg_we && word_ok) begin
      for (int b = 0; b < BYTES; b++) begin
        if (reg_be[b])
          word_q[reg_word][8*b +: 8] <= reg_wdata[8*b +: 8]
                                        & word_mask(int'(reg_word))[8*b +: 8];
      end
    end
  end

  assign reg_rdata = word_ok ? word_q[reg_word] : '0;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cfg
    logic [7:0] ctl;
    assign ctl                = word_q[CTL_WORD][16*w + 8 +: 8];
    assign cfg[w].seg_end     = word_q[w][31:16];
    assign cfg[w].seg_start   = word_q[w][15:0];
    assign cfg[w].xval        = word_q[NUM_WIN + w][31:16];
    assign cfg[w].xsel        = word_q[NUM_WIN + w][15:0];
    assign cfg[w].amsel       = word_q[CTL_WORD][16*w +: 8];
    assign cfg[w].wpost       = ctl[0];
    assign cfg[w].snoop       = ctl[2:1];
    assign cfg[w].adder       = ctl[3];
  end

endmodule

// File: rtl/inwin_slot.sv
module inwin_slot
  import inwin_pkg::*;
(
  input  win_cfg_t         cfg,
  input  logic [SEG_W-1:0] bus_hi,
  input  logic             bus_a24,
  input  logic [1:0]       bus_kind,
  input  logic             bus_sup,
  output logic             match,
  output logic [SEG_W-1:0] loc_hi
);

  logic [SEG_W-1:0] seg;
  logic             in_range;
  logic             class_hit;

  assign seg       = seg_of(bus_hi, bus_a24);
  assign in_range  = (seg >= cfg.seg_start) && (seg <= cfg.seg_end);
  assign class_hit = class_ok(cfg.amsel, bus_kind, bus_a24, bus_sup);
  assign match     = in_range && class_hit;
  assign loc_hi    = xlate(seg, cfg.xval, cfg.xsel, cfg.adder);

endmodule

// File: rtl/inbound_window_map.sv
module inbound_window_map
  import inwin_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [WORD_IDX_W-1:0] reg_word,
  input  logic [BYTES-1:0]      reg_be,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_a24,
  input  logic [1:0]            bus_kind,
  input  logic                  bus_sup,
  output logic                  hit,
  output logic [WIN_IDX_W-1:0]  hit_win,
  output logic [ADDR_W-1:0]     loc_addr,
  output logic                  wpost,
  output logic [1:0]            snoop
);

  win_cfg_t          cfg     [NUM_WIN];
  logic [SEG_W-1:0]  slot_hi [NUM_WIN];
  logic [NUM_WIN-1:0] win_hit;

  inwin_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_word  (reg_word),
    .reg_be    (reg_be),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cfg       (cfg)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_slot
    inwin_slot u_slot (
      .cfg      (cfg[w]),
      .bus_hi   (bus_addr[ADDR_W-1:SEG_W]),
      .bus_a24  (bus_a24),
      .bus_kind (bus_kind),
      .bus_sup  (bus_sup),
      .match    (win_hit[w]),
      .loc_hi   (slot_hi[w])
    );
  end

  // lowest index wins
  logic [WIN_IDX_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--)
      if (win_hit[w]) sel = WIN_IDX_W'(w);
  end

  assign hit      = |win_hit;
  assign hit_win  = hit ? sel : '0;
  assign loc_addr = hit ? {slot_hi[sel], bus_addr[SEG_W-1:0]} : '0;
  assign wpost    = hit ? cfg[sel].wpost : 1'b0;
  assign snoop    = hit ? cfg[sel].snoop : 2'b00;

endmodule

// File: rtl/inwin_chk.sv
module inwin_chk
  import inwin_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_WIN-1:0]      win_hit,
  input logic [NUM_WIN*EN_W-1:0] amsel,
  input logic                    hit,
  input logic [WIN_IDX_W-1:0]    hit_win,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [ADDR_W-1:0]       loc_addr,
  input logic                    wpost,
  input logic [1:0]              snoop
);

  // R6
  zero_en_w0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (amsel[EN_W-1:0] == '0) |-> !win_hit[0]);

  // R6
  zero_en_w1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (amsel[2*EN_W-1:EN_W] == '0) |-> !win_hit[1]);

  // R10
  first_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit[0] |-> (hit && hit_win == '0));

  // R10
  second_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit == 2'b10) |-> (hit && hit_win == 1'b1));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (loc_addr == '0 && !wpost && snoop == 2'b00));

  // R9
  low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (loc_addr[SEG_W-1:0] == bus_addr[SEG_W-1:0]));

endmodule

bind inbound_window_map inwin_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .win_hit  (win_hit),
  .amsel    ({cfg[1].amsel, cfg[0].amsel}),
  .hit      (hit),
  .hit_win  (hit_win),
  .bus_addr (bus_addr),
  .loc_addr (loc_addr),
  .wpost    (wpost),
  .snoop    (snoop)
);

// File: tb/test_inbound_window_map.sv
module test_inbound_window_map;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_word = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] bus_addr = '0;
  logic        bus_a24 = 1'b0;
  logic [1:0]  bus_kind = '0;
  logic        bus_sup = 1'b0;
  logic        hit;
  logic        hit_win;
  logic [31:0] loc_addr;
  logic        wpost;
  logic [1:0]  snoop;

  int checks = 0;
  int errors = 0;
  logic [31:0] sh [5];

  always #4 clk = ~clk;

  inbound_window_map i_inbound_window_map (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_word(reg_word),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_addr(bus_addr), .bus_a24(bus_a24), .bus_kind(bus_kind),
    .bus_sup(bus_sup), .hit(hit), .hit_win(hit_win), .loc_addr(loc_addr),
    .wpost(wpost), .snoop(snoop)
  );

  task automatic wr(input int idx, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] m;
    @(negedge clk);
    reg_we = 1'b1; reg_word = 3'(idx); reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_be = '0;
    if (idx < 5) begin
      m = (idx == 4) ? 32'h0FFF0FFF : 32'hFFFFFFFF;
      for (int b = 0; b < 4; b++)
        if (be[b]) sh[idx][8*b +: 8] = d[8*b +: 8] & m[8*b +: 8];
    end
  endtask

  task automatic rdchk(input int idx, input logic [31:0] exp, input string tag);
    reg_word = 3'(idx);
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s word %0d: actual %08h expected %08h", tag, idx, reg_rdata, exp);
    end
  endtask

  task automatic model(input logic [31:0] a, input logic a24, input logic [1:0] k,
                       input logic sup, output logic eh, output logic ew,
                       output logic [31:0] ela, output logic ewp, output logic [1:0] esn);
    eh = 0; ew = 0; ela = 0; ewp = 0; esn = 0;
    for (int w = 1; w >= 0; w--) begin
      logic [15:0] s, st, en_v, xv, xs, hi;
      logic [7:0] en, ctl;
      logic ok;
      s   = a24 ? (16'(a >> 16) & 16'h00FF) : 16'(a >> 16);
      en  = 8'(sh[4] >> (16*w));
      ctl = 8'(sh[4] >> (16*w + 8));
      st  = sh[w][15:0];
      en_v = sh[w][31:16];
      xv  = sh[2+w][31:16];
      xs  = sh[2+w][15:0];
      ok = ((en >> k) & 8'h1) != 0;
      ok = ok && (a24 ? en[4] : en[5]);
      ok = ok && (sup ? en[7] : en[6]);
      ok = ok && (s >= st) && (s <= en_v);
      if (ok) begin
        if (ctl[3]) hi = 16'((32'(s) + 32'(xv)) % 65536);
        else for (int i = 0; i < 16; i++) hi[i] = xs[i] ? xv[i] : s[i];
        eh = 1; ew = w[0]; ela = {hi, a[15:0]}; ewp = ctl[0]; esn = ctl[2:1];
      end
    end
  endtask

  task automatic cyc(input logic [31:0] a, input logic a24, input logic [1:0] k,
                     input logic sup, input string tag);
    logic eh, ew, ewp;
    logic [31:0] ela;
    logic [1:0] esn;
    bus_addr = a; bus_a24 = a24; bus_kind = k; bus_sup = sup;
    #2;
    model(a, a24, k, sup, eh, ew, ela, ewp, esn);
    checks++;
    if (hit !== eh || (eh && hit_win !== ew) || loc_addr !== ela ||
        wpost !== ewp || snoop !== esn) begin
      errors++;
      $display("FAIL %s addr %08h a24 %0d kind %0d sup %0d: actual hit=%0d win=%0d la=%08h wp=%0d sn=%0d expected hit=%0d win=%0d la=%08h wp=%0d sn=%0d",
               tag, a, a24, k, sup, hit, hit_win, loc_addr, wpost, snoop,
               eh, ew, ela, ewp, esn);
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) sh[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 5; i++) rdchk(i, 32'h0, "R1");
    cyc(32'h0000_0000, 1'b0, 2'd0, 1'b1, "R1");
    cyc(32'h1234_5678, 1'b1, 2'd2, 1'b0, "R1");

    // R2: byte enables, masked control nibbles, unused words
    wr(0, 32'hAABBCCDD, 4'b0101);
    rdchk(0, 32'h00BB00DD, "R2");
    wr(4, 32'hFFFFFFFF, 4'b1111);
    rdchk(4, 32'h0FFF0FFF, "R2");
    wr(5, 32'hFFFFFFFF, 4'b1111);
    rdchk(5, 32'h0, "R2");
    rdchk(0, 32'h00BB00DD, "R2");
    wr(3, 32'h12345678, 4'b1100);
    rdchk(3, 32'h12340000, "R2");
    for (int i = 0; i < 5; i++) wr(i, 32'h0, 4'hF);

    // R3: inclusive bounds, window 1 identity map
    wr(0, 32'h0013_0010, 4'hF);
    wr(4, 32'h0000_00FF, 4'hF);
    for (int s = 0; s < 32; s++) cyc({16'(s), 16'h1234}, 1'b0, 2'd0, 1'b0, "R3");
    cyc(32'h0110_0000, 1'b0, 2'd0, 1'b0, "R3");

    // R4: A24 zeroes the upper byte before compare
    wr(0, 32'h0012_0012, 4'hF);
    for (int u = 0; u < 256; u += 17) begin
      cyc({8'(u), 8'h12, 16'hBEEF}, 1'b1, 2'd1, 1'b1, "R4");
      cyc({8'(u), 8'h12, 16'hBEEF}, 1'b0, 2'd1, 1'b1, "R4");
    end

    // R5, R6: every enable byte against every cycle class
    wr(0, 32'hFFFF_0000, 4'hF);
    for (int e = 0; e < 256; e++) begin
      wr(4, 32'(e), 4'h1);
      for (int k = 0; k < 4; k++)
        for (int c = 0; c < 4; c++)
          cyc(32'h4321_8765, c[0], 2'(k), c[1], (e == 0) ? "R6" : "R5");
    end

    // R7, R9: replacement with several masks
    wr(4, 32'h0000_00FF, 4'hF);
    begin
      logic [15:0] masks [5];
      masks[0] = 16'hFFFF; masks[1] = 16'hFFC0; masks[2] = 16'h00F0;
      masks[3] = 16'h0000; masks[4] = 16'hA5A5;
      for (int m = 0; m < 5; m++) begin
        wr(2, {16'h5A3C, masks[m]}, 4'hF);
        cyc(32'h0000_0001, 1'b0, 2'd0, 1'b0, "R7");
        cyc(32'hC3F1_ABCD, 1'b0, 2'd2, 1'b0, "R7");
        cyc(32'hFFFF_FFFF, 1'b0, 2'd0, 1'b0, "R9");
        cyc(32'h9977_0F0F, 1'b1, 2'd3, 1'b1, "R7");
      end
    end

    // R8: offset mode with wrap and A24 zeroing
    wr(2, 32'hF001_FFFF, 4'hF);
    wr(4, 32'h0000_08FF, 4'h3);
    cyc(32'h0000_1111, 1'b0, 2'd0, 1'b0, "R8");
    cyc(32'h0FFF_2222, 1'b0, 2'd0, 1'b0, "R8");
    cyc(32'h1000_3333, 1'b0, 2'd1, 1'b1, "R8");
    cyc(32'hFFFF_4444, 1'b0, 2'd0, 1'b0, "R8");
    cyc(32'hAB7E_5555, 1'b1, 2'd2, 1'b1, "R8");

    // R10, R11: overlapping windows, distinct controls
    wr(0, 32'h2FFF_1000, 4'hF);
    wr(1, 32'h3FFF_2000, 4'hF);
    wr(2, 32'h8000_F000, 4'hF);
    wr(3, 32'h0100_0000, 4'hF);
    wr(4, 32'h0BFF_05FF, 4'hF);
    cyc(32'h2500_0010, 1'b0, 2'd0, 1'b0, "R10");
    cyc(32'h1000_0020, 1'b0, 2'd3, 1'b1, "R10");
    cyc(32'h3000_0030, 1'b0, 2'd0, 1'b0, "R10");
    cyc(32'h3FFF_0040, 1'b0, 2'd1, 1'b1, "R11");
    cyc(32'h4000_0050, 1'b0, 2'd0, 1'b0, "R11");
    cyc(32'h0FFF_0060, 1'b0, 2'd0, 1'b0, "R11");
    wr(4, 32'h0BFF_0000, 4'h3);
    cyc(32'h2500_0070, 1'b0, 2'd2, 1'b0, "R11");
    cyc(32'h2500_0080, 1'b1, 2'd2, 1'b0, "R11");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule